// File: doc/BRIEF.md
# Paired Table-Driven Mealy and Moore Machines

This block holds two small four-state machines side by side. They share one clock, one synchronous reset and one serial input bit. Each machine walks through its own fixed transition table and produces a 2-bit symbol from it. In the Mealy machine, the symbol is a function of the present state and of the input bit currently on the pin. In the Moore machine, the symbol is decoded from the registered state alone. Both present states and both symbols are visible at the ports, so a consumer can see the timing difference directly. The Mealy symbol reacts to a change of the input within the same cycle. The Moore symbol moves only after the next clock edge.

The input is a plain bit stream with a qualifier, `bit_valid`. A bit is consumed at a rising edge when `bit_valid` is high. The block accepts a bit on every cycle and never applies back-pressure, so there is no ready signal. When `bit_valid` is low, both machines keep their state. The Mealy symbol still shows the table entry for the present state and the bit on the pin.

State codes: A=00, B=01, C=10, D=11. Symbol codes: x1=01, x2=10, x3=11. Code 00 is never produced.

Top module: `dual_fsm_compare`

## Requirements
- R1: A rising edge with `rst` high puts both machines in state A (00). In the cycle after that edge, `moore_out` reads x2 (10).
- R2: On a valid edge the Mealy state advances. For input 0 the transitions are A→B, B→B, C→D and D→D. For input 1 they are A→C, B→D, C→C and D→D.
- R3: `mealy_out` is a combinational function of the present state and `bit_in`. For input 0: A gives x1, B gives x2, C gives x3, D gives x3. For input 1: A gives x1, B gives x3, C gives x1, D gives x2.
- R4: On a valid edge the Moore state advances. For input 0 the transitions are A→B, B→B, C→C and D→D. For input 1 they are A→C, B→D, C→D and D→D.
- R5: `moore_out` depends on the registered state only: A gives x2, B gives x1, C gives x2, D gives x3. A change of `bit_in` between clock edges leaves it unchanged.
- R6: An edge with `bit_valid` low and `rst` low leaves both states unchanged.
- R7: Once the Moore machine reaches D, it stays in D and outputs x3 for any input until the next reset.
- R8: Toggling `bit_in` between clock edges changes `mealy_out` in that same cycle, whenever the table gives different symbols for the two input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Qualifies `bit_in` for consumption at the next edge |
| bit_in | input | 1 | Serial input bit shared by both machines |
| mealy_state | output | 2 | Present Mealy state code |
| mealy_out | output | 2 | Mealy symbol code |
| moore_state | output | 2 | Present Moore state code |
| moore_out | output | 2 | Moore symbol code |

## Verification
The block has no tunable parameters: the state and symbol widths come from package constants, and the bench builds it as it stands. Because the state space is so small, the bench can reach all eight state and input pairs of each table many times over with a few hundred random valid and stalled bits, including resets in the middle of a stream. Directed steps between edges expose the Mealy symbol moving while the Moore symbol stays put. A long run parked in Moore state D shows that D is never left.

// File: rtl/dfsm_pkg.sv
package dfsm_pkg;
  localparam int STATE_W = 2;
  localparam int SYM_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_A = 2'b00,
    ST_B = 2'b01,
    ST_C = 2'b10,
    ST_D = 2'b11
  } st_e;

  typedef enum logic [SYM_W-1:0] {
    SYM_NONE = 2'b00,
    SYM_X1   = 2'b01,
    SYM_X2   = 2'b10,
    SYM_X3   = 2'b11
  } sym_e;
endpackage

// File: rtl/mealy_table_fsm.sv
module mealy_table_fsm
  import dfsm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  input  logic din,
  output st_e  state_o,
  output sym_e sym_o
);
  st_e state_q, state_d;

  // transition and output table, indexed by present state and input bit
  always_comb begin
    state_d = state_q;
    sym_o   = SYM_X1;
    unique case (state_q)
      ST_A: begin state_d = din ? ST_C : ST_B; sym_o = SYM_X1; end
      ST_B: begin state_d = din ? ST_D : ST_B; sym_o = din ? SYM_X3 : SYM_X2; end
      ST_C: begin state_d = din ? ST_C : ST_D; sym_o = din ? SYM_X1 : SYM_X3; end
      ST_D: begin state_d = ST_D;              sym_o = din ? SYM_X2 : SYM_X3; end
      default: begin state_d = ST_A; sym_o = SYM_X1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          state_q <= ST_A;
    else if (step_en) state_q <= state_d;
  end

  assign state_o = state_q;

  // R1
  a_r1_mealy_reset: assert property (@(posedge clk) rst |=> state_q == ST_A);
  // R6
  a_r6_mealy_hold: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(state_q));
  // R2: A is never re-entered from A
  a_r2_leave_a: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_A && step_en) |=> state_q != ST_A);
  // R3: D never emits x1
  a_r3_d_no_x1: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_D |-> sym_o != SYM_X1);
endmodule

// File: rtl/moore_table_fsm.sv
module moore_table_fsm
  import dfsm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  input  logic din,
  output st_e  state_o,
  output sym_e sym_o
);
  st_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_A:    state_d = din ? ST_C : ST_B;
      ST_B:    state_d = din ? ST_D : ST_B;
      ST_C:    state_d = din ? ST_D : ST_C;
      ST_D:    state_d = ST_D;
      default: state_d = ST_A;
    endcase
  end

  // output decode sees the registered state only
  always_comb begin
    unique case (state_q)
      ST_A:    sym_o = SYM_X2;
      ST_B:    sym_o = SYM_X1;
      ST_C:    sym_o = SYM_X2;
      ST_D:    sym_o = SYM_X3;
      default: sym_o = SYM_X2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          state_q <= ST_A;
    else if (step_en) state_q <= state_d;
  end

  assign state_o = state_q;

  // R1
  a_r1_moore_reset: assert property (@(posedge clk) rst |=> state_q == ST_A);
  // R7
  a_r7_d_absorbing: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_D |=> state_q == ST_D);
  // R5
  a_r5_out_stable: assert property (@(posedge clk) disable iff (rst)
    $stable(state_q) |-> $stable(sym_o));
  // R6
  a_r6_moore_hold: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(state_q));
endmodule

// File: rtl/dual_fsm_compare.sv
module dual_fsm_compare
  import dfsm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_valid,
  input  logic               bit_in,
  output logic [STATE_W-1:0] mealy_state,
  output logic [SYM_W-1:0]   mealy_out,
  output logic [STATE_W-1:0] moore_state,
  output logic [SYM_W-1:0]   moore_out
);
  st_e  ml_st, mo_st;
  sym_e ml_sym, mo_sym;

  mealy_table_fsm u_mealy (
    .clk(clk), .rst(rst), .step_en(bit_valid), .din(bit_in),
    .state_o(ml_st), .sym_o(ml_sym)
  );

  moore_table_fsm u_moore (
    .clk(clk), .rst(rst), .step_en(bit_valid), .din(bit_in),
    .state_o(mo_st), .sym_o(mo_sym)
  );

  assign mealy_state = ml_st;
  assign mealy_out   = ml_sym;
  assign moore_state = mo_st;
  assign moore_out   = mo_sym;

  // R4: both machines leave A together and to the same place on a valid step
  a_r4_same_first_step: assert property (@(posedge clk) disable iff (rst)
    (ml_st == ST_A && mo_st == ST_A && bit_valid) |=> ml_st == mo_st);
endmodule

// File: tb/dual_fsm_compare_tb.sv
module dual_fsm_compare_tb;
  logic clk = 1'b0;
  logic rst, bit_valid, bit_in;
  logic [1:0] mealy_state, mealy_out, moore_state, moore_out;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_fsm_compare u_dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .mealy_state(mealy_state), .mealy_out(mealy_out),
    .moore_state(moore_state), .moore_out(moore_out)
  );

  // {rst, valid, in, mealy_state, mealy_out, moore_state, moore_out}
  localparam logic [10:0] VEC [16] = '{
    11'b010_00_01_00_10, 11'b010_01_10_01_01, 11'b011_01_11_01_01,
    11'b000_11_11_11_11, 11'b011_11_10_11_11, 11'b111_11_10_11_11,
    11'b011_00_01_00_10, 11'b011_10_01_10_10, 11'b010_10_11_11_11,
    11'b100_11_11_11_11, 11'b011_00_01_00_10, 11'b010_10_11_10_10,
    11'b010_11_11_10_10, 11'b001_11_10_10_10, 11'b011_11_10_10_10,
    11'b010_11_11_11_11
  };

  function automatic logic [1:0] ref_ml_next(logic [1:0] s, logic b);
    case (s)
      2'b00: return b ? 2'b10 : 2'b01;
      2'b01: return b ? 2'b11 : 2'b01;
      2'b10: return b ? 2'b10 : 2'b11;
      default: return 2'b11;
    endcase
  endfunction
  function automatic logic [1:0] ref_ml_out(logic [1:0] s, logic b);
    case (s)
      2'b00: return 2'b01;
      2'b01: return b ? 2'b11 : 2'b10;
      2'b10: return b ? 2'b01 : 2'b11;
      default: return b ? 2'b10 : 2'b11;
    endcase
  endfunction
  function automatic logic [1:0] ref_mo_next(logic [1:0] s, logic b);
    case (s)
      2'b00: return b ? 2'b10 : 2'b01;
      2'b01: return b ? 2'b11 : 2'b01;
      2'b10: return b ? 2'b11 : 2'b10;
      default: return 2'b11;
    endcase
  endfunction
  function automatic logic [1:0] ref_mo_out(logic [1:0] s);
    case (s)
      2'b00: return 2'b10;
      2'b01: return 2'b01;
      2'b10: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic r, input logic v, input logic b);
    @(negedge clk);
    rst = r; bit_valid = v; bit_in = b;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] ms, Ms;
    rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0;
    drive(1'b1, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    chk(mealy_state, 2'b00, "R1 mealy state after reset");
    chk(moore_state, 2'b00, "R1 moore state after reset");
    chk(moore_out,   2'b10, "R1 moore symbol after reset");

    // table walk, expectations are pre-edge values for the applied input
    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8]);
      chk(mealy_state, VEC[i][7:6], "R2 mealy state (vector)");
      chk(mealy_out,   VEC[i][5:4], "R3 mealy symbol (vector)");
      chk(moore_state, VEC[i][3:2], "R4 moore state (vector)");
      chk(moore_out,   VEC[i][1:0], "R5 moore symbol (vector)");
    end

    // random stream against the table model, stalls and resets included
    drive(1'b1, 1'b0, 1'b0);
    ms = 2'b00; Ms = 2'b00;
    for (int n = 0; n < 400; n++) begin
      logic r, v, b;
      r = ($urandom % 40) == 0;
      v = ($urandom % 4) != 0;
      b = $urandom % 2;
      drive(r, v, b);
      chk(mealy_state, ms, "R2 mealy state (random)");
      chk(mealy_out, ref_ml_out(ms, b), "R3 mealy symbol (random)");
      chk(moore_state, Ms, "R4 moore state (random)");
      chk(moore_out, ref_mo_out(Ms), "R5 moore symbol (random)");
      if (r) begin ms = 2'b00; Ms = 2'b00; end
      else if (v) begin ms = ref_ml_next(ms, b); Ms = ref_mo_next(Ms, b); end
      // R6: stalled edges keep the model (and the design) in place
    end

    // R6 directed: a stalled edge leaves both states in place
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0);   // A -> B on both
    drive(1'b0, 1'b0, 1'b1);
    chk(mealy_state, 2'b01, "R6 mealy state before stall");
    drive(1'b0, 1'b0, 1'b1);
    chk(mealy_state, 2'b01, "R6 mealy state held");
    chk(moore_state, 2'b01, "R6 moore state held");

    // R8 and R5: toggle the input between edges, Mealy moves, Moore does not
    @(negedge clk); bit_in = 1'b0; #1;
    chk(mealy_out, 2'b10, "R8 mealy symbol B/in0");
    chk(moore_out, 2'b01, "R5 moore symbol B/in0");
    #0.5 bit_in = 1'b1; #0.2;
    chk(mealy_out, 2'b11, "R8 mealy symbol B/in1 same cycle");
    chk(moore_out, 2'b01, "R5 moore symbol unchanged by input");

    // R7: drive Moore into D and hammer it
    drive(1'b0, 1'b1, 1'b1);   // B -> D
    for (int k = 0; k < 40; k++) begin
      drive(1'b0, ($urandom % 2) == 1, ($urandom % 2) == 1);
      chk(moore_state, 2'b11, "R7 moore stays in D");
      chk(moore_out,   2'b11, "R7 moore symbol x3 in D");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule